// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns one host request into a single asynchronous bus cycle on an 8-bit or 16-bit NAND device. The request names one of three targets: command, address or data. It also gives the direction and, for a write, the value to drive. The sequencer keeps chip enable low for the whole cycle. It raises the command-latch or address-latch line for the matching target, pulses write enable or read enable, and drives or releases the data bus.

Every phase of the cycle has its own length, read from two configuration words. A timing word gives the setup, strobe, hold and bus-release counts. A control word gives the bank enable, the device-type select, the bus width and two latch-to-read-enable delays. All counts are in controller clock cycles.

The sequencer remembers the previous enabled access. It uses that to insert a bus-release gap before a write that follows a read, and a settle gap before a read that follows a command or address cycle. Read data is captured when read enable rises. It is returned with a one-cycle acknowledge.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, and `nand_cle`, `nand_ale`, `nand_dq_oe` and `ack` are low.
- R2: `req_port` code 0 (command) holds `nand_cle` high and code 1 (address) holds `nand_ale` high, for every cycle of the setup, strobe and hold phases. Codes 2 and 3 (data) raise neither line.
- R3: In an access, chip enable is low with the strobe high for the setup count (timing word bits [7:0]). The strobe is then low for the wait count (bits [15:8]). Chip enable then stays low with the strobe high for the hold count (bits [23:16]).
- R4: A write pulses `nand_we_n` and drives `nand_dq_oe` high through setup, strobe and hold. `nand_dq_out` is stable while the strobe is low. A read pulses `nand_re_n` with `nand_dq_oe` low.
- R5: A read returns on `rdata` the value present on `nand_dq_in` in the last strobe-low cycle. The value is valid when `ack` is high and is held until the next read.
- R6: A write whose previous enabled access was a read keeps chip enable low with `nand_dq_oe` low for the release count (timing word bits [31:24]) before setup. A release count of 0 skips this gap, and there is no gap after a write.
- R7: A read whose previous enabled access targeted command gets extra chip-enable-low cycles before setup, equal to control bits [12:9]. After an address access the count comes from control bits [16:13]. In both cases the latch lines are low during these cycles.
- R8: A setup, wait or hold count of 0 acts as 1.
- R9: With control bit 4 set, the data path is 16 bits. With it clear, the upper byte of `nand_dq_out` and of `rdata` is zero.
- R10: Unless control bits 2 and 3 are both set, a request is acknowledged in the first cycle after acceptance with no device strobe. A read then returns zero, and the previous-access history is left unchanged.
- R11: `ack` is high for exactly one cycle per request, with `nand_ce_n` high. The host drops `req` in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 32 | Control word: enables, width, latch-to-read delays |
| timing_word | input | 32 | Timing word: setup, wait, hold, release counts |
| req | input | 1 | Access request, held until acknowledge |
| req_port | input | 2 | Target: 0 command, 1 address, 2 or 3 data |
| req_wr | input | 1 | 1 write, 0 read |
| req_wdata | input | DQ_W | Write value |
| ack | output | 1 | One-cycle access completion |
| rdata | output | DQ_W | Captured read value |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_out | output | DQ_W | Data bus drive value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | DQ_W | Data bus sample |

## Verification
A phase counter loaded with the wrong field, or off by one, shows up in the first access as a setup, strobe or hold run of the wrong length on `nand_ce_n` and the strobes. A corrupted history flag appears only one access later, as a missing or spurious release or settle gap in front of the next cycle. The directed sequences therefore chain read, write, command and address accesses back to back, and measure each cycle's phase lengths at the pins. A capture taken in the wrong cycle returns the junk value the bench places on the bus outside the strobe window, and shows on `rdata` at the acknowledge of that same access.

// File: rtl/nand_seq_pkg.sv
// Shared types for the NAND bus cycle sequencer.
// Assumes count fields fit CNT_W bits and latch delays fit DLY_W bits.
package nand_seq_pkg;
    localparam int CNT_W = 8;
    localparam int DLY_W = 4;

    typedef enum logic [1:0] {
        PORT_CMD  = 2'd0,
        PORT_ADDR = 2'd1,
        PORT_DATA = 2'd2,
        PORT_DAT2 = 2'd3
    } port_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_TURN  = 3'd1,
        PH_DLY   = 3'd2,
        PH_SETUP = 3'd3,
        PH_WAIT  = 3'd4,
        PH_HOLD  = 3'd5,
        PH_ACK   = 3'd6
    } phase_e;

    typedef struct packed {
        logic             enable;
        logic             wide;
        logic [DLY_W-1:0] cle_re;
        logic [DLY_W-1:0] ale_re;
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] hiz;
    } cfg_t;

    // Raise a zero count to one cycle
    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction
endpackage

// File: rtl/nand_cfg_decode.sv
// Decodes the control and timing words into a config record.
// Setup, wait and hold are clamped to at least one cycle; the
// release count and latch delays keep zero as "skip".
module nand_cfg_decode
    import nand_seq_pkg::*;
(
    input  logic [31:0] ctrl_word,
    input  logic [31:0] timing_word,
    output cfg_t        cfg
);
    localparam int BIT_BANK = 2;
    localparam int BIT_NAND = 3;
    localparam int BIT_WIDE = 4;
    localparam int CLE_LSB  = 9;
    localparam int ALE_LSB  = CLE_LSB + DLY_W;
    localparam int NFIELD   = 3;

    logic [NFIELD-1:0][CNT_W-1:0] raw_cnt;
    logic [NFIELD-1:0][CNT_W-1:0] min_cnt;
    logic                          unused_ctrl;

    assign raw_cnt[0] = timing_word[0*CNT_W +: CNT_W];
    assign raw_cnt[1] = timing_word[1*CNT_W +: CNT_W];
    assign raw_cnt[2] = timing_word[2*CNT_W +: CNT_W];

    // One clamp per main phase count
    for (genvar f = 0; f < NFIELD; f++) begin : g_clamp
        assign min_cnt[f] = at_least_one(raw_cnt[f]);
    end

    // Assemble the record
    always_comb begin
        cfg.enable = ctrl_word[BIT_BANK] & ctrl_word[BIT_NAND];
        cfg.wide   = ctrl_word[BIT_WIDE];
        cfg.cle_re = ctrl_word[CLE_LSB +: DLY_W];
        cfg.ale_re = ctrl_word[ALE_LSB +: DLY_W];
        cfg.setup  = min_cnt[0];
        cfg.strobe = min_cnt[1];
        cfg.hold   = min_cnt[2];
        cfg.hiz    = timing_word[3*CNT_W +: CNT_W];
    end

    assign unused_ctrl = ^{ctrl_word[31:ALE_LSB+DLY_W], ctrl_word[CLE_LSB-1:BIT_WIDE+1],
                           ctrl_word[BIT_BANK-1:0]};
endmodule

// File: rtl/nand_phase_timer.sv
// Down counter timing one phase. Loaded with N on phase entry;
// expire is high in the phase's last cycle. Assumes N >= 1.
module nand_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    // Load on entry, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == W'(1));
endmodule

// File: rtl/nand_phase_fsm.sv
// Phase sequencer: chooses the first phase from the request and
// the previous access, then steps setup -> wait -> hold -> ack.
// Assumes cfg_q equals cfg_live in the cycle a request is accepted.
module nand_phase_fsm
    import nand_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  cfg_t             cfg_live,
    input  cfg_t             cfg_q,
    input  logic             last_rd,
    input  port_e            last_port,
    input  logic             expire,
    output phase_e           phase,
    output logic             accept,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val
);
    phase_e ph_q;
    phase_e ph_d;

    assign phase  = ph_q;
    assign accept = (ph_q == PH_IDLE) && req;

    // Next phase and timer load value
    always_comb begin
        ph_d   = ph_q;
        t_load = 1'b0;
        t_val  = '0;
        unique case (ph_q)
            PH_IDLE: begin
                if (req) begin
                    t_load = 1'b1;
                    if (!cfg_live.enable) begin
                        ph_d   = PH_ACK;
                        t_load = 1'b0;
                    end else if (req_wr && last_rd && (cfg_live.hiz != '0)) begin
                        ph_d  = PH_TURN;
                        t_val = cfg_live.hiz;
                    end else if (!req_wr && (last_port == PORT_CMD) && (cfg_live.cle_re != '0)) begin
                        ph_d  = PH_DLY;
                        t_val = CNT_W'(cfg_live.cle_re);
                    end else if (!req_wr && (last_port == PORT_ADDR) && (cfg_live.ale_re != '0)) begin
                        ph_d  = PH_DLY;
                        t_val = CNT_W'(cfg_live.ale_re);
                    end else begin
                        ph_d  = PH_SETUP;
                        t_val = cfg_live.setup;
                    end
                end
            end
            PH_TURN, PH_DLY: begin
                if (expire) begin
                    ph_d   = PH_SETUP;
                    t_load = 1'b1;
                    t_val  = cfg_q.setup;
                end
            end
            PH_SETUP: begin
                if (expire) begin
                    ph_d   = PH_WAIT;
                    t_load = 1'b1;
                    t_val  = cfg_q.strobe;
                end
            end
            PH_WAIT: begin
                if (expire) begin
                    ph_d   = PH_HOLD;
                    t_load = 1'b1;
                    t_val  = cfg_q.hold;
                end
            end
            PH_HOLD: begin
                if (expire) begin
                    ph_d = PH_ACK;
                end
            end
            PH_ACK: begin
                ph_d = PH_IDLE;
            end
            default: begin
                ph_d = PH_IDLE;
            end
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end
endmodule

// File: rtl/nand_strobe_seq.sv
// Top of the NAND bus cycle sequencer. Latches the access and the
// configuration at acceptance, drives the device pins from the
// current phase, captures read data and keeps the access history.
// Assumes the host holds req until ack and drops it in the ack cycle.
module nand_strobe_seq
    import nand_seq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     ctrl_word,
    input  logic [31:0]     timing_word,
    input  logic            req,
    input  logic [1:0]      req_port,
    input  logic            req_wr,
    input  logic [DQ_W-1:0] req_wdata,
    output logic            ack,
    output logic [DQ_W-1:0] rdata,
    output logic            nand_ce_n,
    output logic            nand_cle,
    output logic            nand_ale,
    output logic            nand_we_n,
    output logic            nand_re_n,
    output logic [DQ_W-1:0] nand_dq_out,
    output logic            nand_dq_oe,
    input  logic [DQ_W-1:0] nand_dq_in
);
    localparam int LANES = DQ_W / 8;

    cfg_t             cfg_live;
    cfg_t             cfg_q;
    phase_e           phase;
    logic             accept;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             expire;

    port_e            acc_port_q;
    logic             acc_wr_q;
    logic             acc_en_q;
    logic [DQ_W-1:0]  acc_wdata_q;
    logic [DQ_W-1:0]  rdata_q;
    logic             last_rd_q;
    port_e            last_port_q;

    logic [DQ_W-1:0]  mask_live;
    logic [DQ_W-1:0]  mask_q;
    logic             busy;
    logic             sel;

    nand_cfg_decode u_decode (
        .ctrl_word   (ctrl_word),
        .timing_word (timing_word),
        .cfg         (cfg_live)
    );

    nand_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .cfg_live  (cfg_live),
        .cfg_q     (cfg_q),
        .last_rd   (last_rd_q),
        .last_port (last_port_q),
        .expire    (expire),
        .phase     (phase),
        .accept    (accept),
        .t_load    (t_load),
        .t_val     (t_val)
    );

    nand_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expire   (expire)
    );

    // Byte-lane masks: lane 0 always live, upper lanes only when wide
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign mask_live[g*8 +: 8] = 8'hFF;
            assign mask_q[g*8 +: 8]    = 8'hFF;
        end else begin : g_high
            assign mask_live[g*8 +: 8] = {8{cfg_live.wide}};
            assign mask_q[g*8 +: 8]    = {8{cfg_q.wide}};
        end
    end

    // Track the configuration while idle, freeze it during an access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (phase == PH_IDLE) begin
            cfg_q <= cfg_live;
        end
    end

    // Latch the accepted access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_port_q  <= PORT_DATA;
            acc_wr_q    <= 1'b0;
            acc_en_q    <= 1'b0;
            acc_wdata_q <= '0;
        end else if (accept) begin
            acc_port_q  <= port_e'(req_port);
            acc_wr_q    <= req_wr;
            acc_en_q    <= cfg_live.enable;
            acc_wdata_q <= req_wdata & mask_live;
        end
    end

    // Capture read data at the end of the strobe, or zero on a disabled read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept && !cfg_live.enable && !req_wr) begin
            rdata_q <= '0;
        end else if ((phase == PH_WAIT) && !acc_wr_q && expire) begin
            rdata_q <= nand_dq_in & mask_q;
        end
    end

    // Record the previous enabled access at its acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd_q   <= 1'b0;
            last_port_q <= PORT_DATA;
        end else if ((phase == PH_ACK) && acc_en_q) begin
            last_rd_q   <= !acc_wr_q;
            last_port_q <= acc_port_q;
        end
    end

    // Decode pin levels from the phase
    always_comb begin
        busy = (phase == PH_TURN) || (phase == PH_DLY) || (phase == PH_SETUP) ||
               (phase == PH_WAIT) || (phase == PH_HOLD);
        sel  = (phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_HOLD);
    end

    assign nand_ce_n   = !busy;
    assign nand_cle    = sel && (acc_port_q == PORT_CMD);
    assign nand_ale    = sel && (acc_port_q == PORT_ADDR);
    assign nand_we_n   = !((phase == PH_WAIT) && acc_wr_q);
    assign nand_re_n   = !((phase == PH_WAIT) && !acc_wr_q);
    assign nand_dq_oe  = sel && acc_wr_q;
    assign nand_dq_out = nand_dq_oe ? acc_wdata_q : '0;
    assign ack         = (phase == PH_ACK);
    assign rdata       = rdata_q;
endmodule

// File: rtl/nand_strobe_seq_chk.sv
// Pin-level protocol checks for the NAND bus cycle sequencer,
// attached to every instance of the top by bind.
module nand_strobe_seq_chk #(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack,
    input logic            nand_ce_n,
    input logic            nand_cle,
    input logic            nand_ale,
    input logic            nand_we_n,
    input logic            nand_re_n,
    input logic            nand_dq_oe,
    input logic [DQ_W-1:0] nand_dq_out
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R4

    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R3

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R2

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R11

    AST_ACK_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> nand_ce_n); // R11

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe); // R4

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out)); // R4
endmodule

bind nand_strobe_seq nand_strobe_seq_chk #(.DQ_W(DQ_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_oe  (nand_dq_oe),
    .nand_dq_out (nand_dq_out)
);

// File: tb/test_nand_strobe_seq.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each measuring phase
// lengths at the pins and checking its own results.
module test_nand_strobe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] timing_word = '0;
    logic        req = 1'b0;
    logic [1:0]  req_port = '0;
    logic        req_wr = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int r_pre, r_strb, r_post, r_cle, r_ale, r_oeoff, r_cyc, r_bad, r_timeout;
    logic [15:0] r_wd, r_rdata;
    logic r_ce_at_ack, r_ack_after;

    always #4 clk = ~clk;

    nand_strobe_seq i_nand_strobe_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .timing_word(timing_word),
        .req(req), .req_port(req_port), .req_wr(req_wr), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
    );

    function automatic logic [31:0] mk_ctrl(bit bank, bit nand_sel, bit wide, int cle_re, int ale_re);
        return (32'(bank) << 2) | (32'(nand_sel) << 3) | (32'(wide) << 4) |
               (32'(cle_re & 15) << 9) | (32'(ale_re & 15) << 13) | 32'h2;
    endfunction

    function automatic logic [31:0] mk_tim(int su, int wt, int hd, int hz);
        return {8'(hz), 8'(hd), 8'(wt), 8'(su)};
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // Run one access and record its pin-level shape
    task automatic run_acc(input logic [1:0] port, input logic wr,
                           input logic [15:0] wd, input logic [15:0] good);
        logic seen;
        seen = 1'b0;
        r_pre = 0; r_strb = 0; r_post = 0; r_cle = 0; r_ale = 0; r_oeoff = 0;
        r_cyc = 0; r_bad = 0; r_timeout = 0; r_wd = '0;
        @(negedge clk);
        req = 1'b1; req_port = port; req_wr = wr; req_wdata = wd; nand_dq_in = 16'h5A5A;
        forever begin
            @(negedge clk);
            r_cyc++;
            if (ack) begin
                r_rdata = rdata; r_ce_at_ack = nand_ce_n; req = 1'b0;
                break;
            end
            if (r_cyc > 2000) begin
                r_timeout = 1; req = 1'b0;
                break;
            end
            if (!nand_ce_n) begin
                if (!nand_we_n || !nand_re_n) begin
                    r_strb++; seen = 1'b1;
                    if (!nand_we_n) r_wd = nand_dq_out;
                    if (!nand_re_n) nand_dq_in = good;
                    if (!nand_re_n && nand_dq_oe) r_bad++;
                    if (!nand_we_n && !nand_dq_oe) r_bad++;
                end else if (!seen) begin
                    r_pre++;
                    if (!nand_dq_oe) r_oeoff++;
                end else begin
                    r_post++;
                    nand_dq_in = 16'hC3C3;
                end
                r_cle += int'(nand_cle);
                r_ale += int'(nand_ale);
            end else if (!nand_we_n || !nand_re_n || nand_cle || nand_ale || nand_dq_oe) begin
                r_bad++;
            end
        end
        @(negedge clk);
        r_ack_after = ack;
    endtask

    task automatic shape(string tag, int pre, int strb, int post);
        check({tag, " setup-side cycles"}, r_pre, pre);
        check({tag, " strobe cycles"}, r_strb, strb);
        check({tag, " hold cycles"}, r_post, post);
        check({tag, " total cycles"}, r_cyc, pre + strb + post + 1);
        check({tag, " stray pin activity"}, r_bad, 0);
        check({tag, " timeout"}, r_timeout, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle pins", int'({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, ack}),
              int'(7'b1110000));
    endtask

    task automatic t_cmd_write;
        ctrl_word = mk_ctrl(1, 1, 0, 5, 3);
        timing_word = mk_tim(2, 3, 2, 4);
        run_acc(2'd0, 1'b1, 16'hA5C3, 16'h0);
        shape("R3 command write", 2, 3, 2);
        check("R2 cle cycles on command", r_cle, 7);
        check("R2 ale cycles on command", r_ale, 0);
        check("R4 write keeps bus driven before strobe", r_oeoff, 0);
        check("R9 narrow write value", int'(r_wd), 32'h00C3);
        check("R11 ce high at ack", int'(r_ce_at_ack), 1);
        check("R11 ack lasts one cycle", int'(r_ack_after), 0);
    endtask

    task automatic t_read_after_cmd;
        run_acc(2'd2, 1'b0, 16'h0, 16'h3C7E);
        shape("R7 read after command", 5 + 2, 3, 2);
        check("R7 no latch line on data read", r_cle + r_ale, 0);
        check("R5 read capture narrow", int'(r_rdata), 32'h007E);
    endtask

    task automatic t_write_after_read;
        ctrl_word = mk_ctrl(1, 1, 1, 5, 3);
        run_acc(2'd2, 1'b1, 16'hBEEF, 16'h0);
        shape("R6 write after read", 4 + 2, 3, 2);
        check("R6 released-bus cycles", r_oeoff, 4);
        check("R9 wide write value", int'(r_wd), 32'hBEEF);
        check("R5 rdata held over write", int'(rdata), 32'h007E);
    endtask

    task automatic t_addr_write;
        run_acc(2'd1, 1'b1, 16'h0042, 16'h0);
        shape("R6 write after write", 2, 3, 2);
        check("R6 no release gap", r_oeoff, 0);
        check("R2 ale cycles on address", r_ale, 7);
        check("R2 cle cycles on address", r_cle, 0);
    endtask

    task automatic t_read_after_addr;
        run_acc(2'd3, 1'b0, 16'h0, 16'h9A61);
        shape("R7 read after address", 3 + 2, 3, 2);
        check("R2 port code 3 raises no latch", r_cle + r_ale, 0);
        check("R5 R9 wide read capture", int'(r_rdata), 32'h9A61);
    endtask

    task automatic t_zero_counts;
        timing_word = mk_tim(0, 0, 0, 0);
        run_acc(2'd2, 1'b1, 16'h1234, 16'h0);
        shape("R8 zero counts act as one", 1, 1, 1);
        check("R6 zero release count skips gap", r_oeoff, 0);
        run_acc(2'd2, 1'b0, 16'h0, 16'h0F0F);
        shape("R8 zero-count read", 1, 1, 1);
        check("R5 capture at strobe end", int'(r_rdata), 32'h0F0F);
    endtask

    task automatic t_disabled;
        ctrl_word = mk_ctrl(0, 1, 1, 5, 3);
        run_acc(2'd0, 1'b1, 16'hFFFF, 16'h0);
        check("R10 disabled ack latency", r_cyc, 1);
        check("R10 disabled no chip enable", r_pre + r_strb + r_post, 0);
        check("R10 disabled no stray pins", r_bad, 0);
        check("R5 rdata held over disabled write", int'(rdata), 32'h0F0F);
        ctrl_word = mk_ctrl(1, 0, 1, 5, 3);
        run_acc(2'd2, 1'b0, 16'h0, 16'h7777);
        check("R10 type-select clear ack latency", r_cyc, 1);
        check("R10 type-select clear no strobe", r_strb, 0);
        check("R10 disabled read returns zero", int'(r_rdata), 0);
        ctrl_word = mk_ctrl(1, 1, 1, 5, 3);
        timing_word = mk_tim(1, 2, 1, 2);
        run_acc(2'd2, 1'b1, 16'h2468, 16'h0);
        shape("R10 history kept across disabled", 2 + 1, 2, 1);
        check("R10 R6 release gap still owed", r_oeoff, 2);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cmd_write();
        t_read_after_cmd();
        t_write_after_read();
        t_addr_write();
        t_read_after_addr();
        t_zero_counts();
        t_disabled();
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule